// File: doc/BRIEF.md
# Battery Stack Alarm Combiner

This block turns the comparator flags of a six-cell, two-sensor battery monitor into three alarm signals: overvoltage, undervoltage and overtemperature. It takes one overvoltage and one undervoltage flag per cell, plus one "above threshold" flag per temperature sensor. Configuration inputs set how many cells are in use, which thermistor type is fitted, and whether the three alarms are kept apart or merged into one shared condition.

Several monitors can be stacked in a chain. A two-bit position code says where this part sits. A middle or bottom part merges the alarm inputs coming from the part above into its own alarms. A top or standalone part ignores those inputs. The resulting alarms drive both the local outputs and the chain outputs that go to the part below. The local outputs therefore report this part together with every part above it.

All outputs are registered: a change at the inputs appears at the outputs one clock later. An enable input forces every alarm low while it is low.

Top module: `batt_alarm_combiner`

## Requirements
- R1: `cell_sel` sets the number of live cells to 6 minus its value (00 gives six, 01 five, 10 four, 11 three). Only cells 0 up to that count minus one take part in overvoltage and undervoltage detection. The flags of the higher cells have no effect.
- R2: With `ptc_mode` low, a sensor is in overtemperature when its `temp_above` bit is 0. With `ptc_mode` high, a sensor is in overtemperature when its bit is 1. Either sensor can raise the overtemperature alarm.
- R3: With `separate_mode` high, each of the three alarms follows only its own condition class, taken across all live channels and, where accepted, the matching upstream input.
- R4: With `separate_mode` low, any overvoltage, undervoltage, overtemperature or accepted upstream alarm drives all three alarms high together. Otherwise all three are low.
- R5: `chain_pos` is {top, bottom}. For 00 (middle) and 01 (bottom), each upstream input `up_ov`, `up_uv`, `up_ot` is ORed into the matching alarm.
- R6: For `chain_pos` 10 (top) and 11 (single), the upstream inputs have no effect on any output.
- R7: While `enable` is low, all six alarm outputs are low one cycle later, whatever the flags are.
- R8: The outputs are registered with one cycle of latency and are low during reset. Each chain output equals the matching local alarm output. High means alarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High enables alarm generation |
| cell_ov | input | 6 | Per-cell overvoltage flag, bit i for cell i |
| cell_uv | input | 6 | Per-cell undervoltage flag, bit i for cell i |
| temp_above | input | 2 | Per-sensor flag, 1 when the input is above its threshold |
| cell_sel | input | 2 | Live cell count select |
| ptc_mode | input | 1 | 0 for NTC thermistors, 1 for PTC thermistors |
| separate_mode | input | 1 | 1 for separate alarms, 0 for one shared alarm |
| chain_pos | input | 2 | Chain position code {top, bottom} |
| up_ov | input | 1 | Overvoltage alarm from the part above |
| up_uv | input | 1 | Undervoltage alarm from the part above |
| up_ot | input | 1 | Overtemperature alarm from the part above |
| alarm_ov | output | 1 | Local overvoltage alarm |
| alarm_uv | output | 1 | Local undervoltage alarm |
| alarm_ot | output | 1 | Local overtemperature alarm |
| chain_ov | output | 1 | Overvoltage alarm toward the part below |
| chain_uv | output | 1 | Undervoltage alarm toward the part below |
| chain_ot | output | 1 | Overtemperature alarm toward the part below |

## Verification
The assertions check on every cycle the rules that follow from a few input bits alone:
- the outputs go quiet one cycle after `enable` drops;
- the three outputs are equal in shared mode;
- an accepted upstream alarm passes through;
- a top-positioned part stays quiet when it has no local overvoltage flags;
- a sixth-cell overvoltage in six-cell mode raises the alarm;
- an NTC sensor below its threshold raises the overtemperature alarm.

The masking of the highest cells at each count, the PTC sense, class isolation in separate mode and the chain outputs matching the local ones need the bench's directed and pseudo-random scenarios. In those scenarios every output is compared with an independently computed value.

// File: rtl/battmon_pkg.sv
package battmon_pkg;

  typedef enum logic [1:0] {
    POS_MIDDLE = 2'b00,
    POS_BOTTOM = 2'b01,
    POS_TOP    = 2'b10,
    POS_SINGLE = 2'b11
  } chain_pos_e;

  typedef struct packed {
    logic ov;
    logic uv;
    logic ot;
  } alarm_set_t;

  // Number of live cells for a given count select (R1)
  function automatic int unsigned live_cells(int unsigned total, logic [7:0] sel);
    return total - 32'(sel);
  endfunction

  // Positions below the top of the chain accept upstream alarms (R5, R6)
  function automatic logic takes_upstream(logic [1:0] pos);
    return (pos == POS_MIDDLE) || (pos == POS_BOTTOM);
  endfunction

  // Thermistor polarity decides which side of the threshold is hot (R2)
  function automatic logic is_hot(logic above, logic ptc);
    return ptc ? above : !above;
  endfunction

endpackage

// File: rtl/cell_window_mask.sv
module cell_window_mask #(
  parameter int unsigned NUM_CELLS = 6,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [NUM_CELLS-1:0] cell_ov,
  input  logic [NUM_CELLS-1:0] cell_uv,
  input  logic [SEL_W-1:0]     cell_sel,
  output logic                 any_ov,
  output logic                 any_uv
);
  import battmon_pkg::*;

  localparam int unsigned SEL_PAD = 8 - SEL_W;

  logic [NUM_CELLS-1:0] live;

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_live
    assign live[g] = (32'(g) < live_cells(NUM_CELLS, {{SEL_PAD{1'b0}}, cell_sel}));
  end

  assign any_ov = |(cell_ov & live);
  assign any_uv = |(cell_uv & live);

endmodule

// File: rtl/temp_sense.sv
module temp_sense #(
  parameter int unsigned NUM_TEMPS = 2
) (
  input  logic [NUM_TEMPS-1:0] temp_above,
  input  logic                 ptc_mode,
  output logic                 any_ot
);
  import battmon_pkg::*;

  logic [NUM_TEMPS-1:0] hot;

  for (genvar g = 0; g < NUM_TEMPS; g++) begin : g_hot
    assign hot[g] = is_hot(temp_above[g], ptc_mode);
  end

  assign any_ot = |hot;

endmodule

// File: rtl/alarm_merge.sv
module alarm_merge (
  input  battmon_pkg::alarm_set_t local_hits,
  input  battmon_pkg::alarm_set_t upstream,
  input  logic [1:0]              chain_pos,
  input  logic                    separate_mode,
  output battmon_pkg::alarm_set_t merged
);
  import battmon_pkg::*;

  logic       accept_up;
  alarm_set_t gated_up;
  alarm_set_t per_class;
  logic       any_alarm;

  assign accept_up = takes_upstream(chain_pos);
  assign gated_up  = accept_up ? upstream : '0;
  assign per_class = local_hits | gated_up;
  assign any_alarm = per_class.ov | per_class.uv | per_class.ot;

  always_comb begin
    if (separate_mode) begin
      merged = per_class;
    end else begin
      merged = '{ov: any_alarm, uv: any_alarm, ot: any_alarm};
    end
  end

endmodule

// File: rtl/batt_alarm_combiner.sv
module batt_alarm_combiner #(
  parameter int unsigned NUM_CELLS = 6,
  parameter int unsigned NUM_TEMPS = 2,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_CELLS-1:0] cell_ov,
  input  logic [NUM_CELLS-1:0] cell_uv,
  input  logic [NUM_TEMPS-1:0] temp_above,
  input  logic [SEL_W-1:0]     cell_sel,
  input  logic                 ptc_mode,
  input  logic                 separate_mode,
  input  logic [1:0]           chain_pos,
  input  logic                 up_ov,
  input  logic                 up_uv,
  input  logic                 up_ot,
  output logic                 alarm_ov,
  output logic                 alarm_uv,
  output logic                 alarm_ot,
  output logic                 chain_ov,
  output logic                 chain_uv,
  output logic                 chain_ot
);
  import battmon_pkg::*;

  alarm_set_t local_hits;
  alarm_set_t upstream;
  alarm_set_t merged;
  alarm_set_t next_alarm;
  alarm_set_t alarm_q;

  cell_window_mask #(
    .NUM_CELLS(NUM_CELLS),
    .SEL_W    (SEL_W)
  ) i_cells (
    .cell_ov (cell_ov),
    .cell_uv (cell_uv),
    .cell_sel(cell_sel),
    .any_ov  (local_hits.ov),
    .any_uv  (local_hits.uv)
  );

  temp_sense #(
    .NUM_TEMPS(NUM_TEMPS)
  ) i_temp (
    .temp_above(temp_above),
    .ptc_mode  (ptc_mode),
    .any_ot    (local_hits.ot)
  );

  assign upstream = '{ov: up_ov, uv: up_uv, ot: up_ot};

  alarm_merge i_merge (
    .local_hits   (local_hits),
    .upstream     (upstream),
    .chain_pos    (chain_pos),
    .separate_mode(separate_mode),
    .merged       (merged)
  );

  assign next_alarm = enable ? merged : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
    end else begin
      alarm_q <= next_alarm;
    end
  end

  assign alarm_ov = alarm_q.ov;
  assign alarm_uv = alarm_q.uv;
  assign alarm_ot = alarm_q.ot;
  assign chain_ov = alarm_q.ov;
  assign chain_uv = alarm_q.uv;
  assign chain_ot = alarm_q.ot;

endmodule

// File: rtl/batt_alarm_combiner_chk.sv
module batt_alarm_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [5:0] cell_ov,
  input logic [1:0] temp_above,
  input logic [1:0] cell_sel,
  input logic       ptc_mode,
  input logic       separate_mode,
  input logic [1:0] chain_pos,
  input logic       up_ov,
  input logic       alarm_ov,
  input logic       alarm_uv,
  input logic       alarm_ot
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!alarm_ov && !alarm_uv && !alarm_ot)); // R7

  AST_SHARED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !separate_mode |=> (alarm_ov == alarm_uv) && (alarm_uv == alarm_ot)); // R4

  AST_UPSTREAM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !chain_pos[1] && up_ov) |=> alarm_ov); // R5

  AST_TOP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && separate_mode && chain_pos[1] && cell_ov == 6'b0) |=> !alarm_ov); // R6

  AST_SIXTH_CELL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cell_sel == 2'b00 && cell_ov[5]) |=> alarm_ov); // R1

  AST_NTC_COLD_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && separate_mode && !ptc_mode && !temp_above[0]) |=> alarm_ot); // R2

endmodule

bind batt_alarm_combiner batt_alarm_combiner_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cell_ov      (cell_ov),
  .temp_above   (temp_above),
  .cell_sel     (cell_sel),
  .ptc_mode     (ptc_mode),
  .separate_mode(separate_mode),
  .chain_pos    (chain_pos),
  .up_ov        (up_ov),
  .alarm_ov     (alarm_ov),
  .alarm_uv     (alarm_uv),
  .alarm_ot     (alarm_ot)
);

// File: tb/test_batt_alarm_combiner.sv
`timescale 1ns/1ps
module test_batt_alarm_combiner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] cell_ov = '0;
  logic [5:0] cell_uv = '0;
  logic [1:0] temp_above = 2'b11;
  logic [1:0] cell_sel = '0;
  logic       ptc_mode = 1'b0;
  logic       separate_mode = 1'b1;
  logic [1:0] chain_pos = 2'b11;
  logic       up_ov = 1'b0, up_uv = 1'b0, up_ot = 1'b0;
  logic       alarm_ov, alarm_uv, alarm_ot, chain_ov, chain_uv, chain_ot;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sbq[$];

  always #2.5 clk = ~clk;

  batt_alarm_combiner i_batt_alarm_combiner (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cell_ov(cell_ov), .cell_uv(cell_uv), .temp_above(temp_above),
    .cell_sel(cell_sel), .ptc_mode(ptc_mode), .separate_mode(separate_mode),
    .chain_pos(chain_pos), .up_ov(up_ov), .up_uv(up_uv), .up_ot(up_ot),
    .alarm_ov(alarm_ov), .alarm_uv(alarm_uv), .alarm_ot(alarm_ot),
    .chain_ov(chain_ov), .chain_uv(chain_uv), .chain_ot(chain_ot)
  );

  // Reference model: {alarm_ov, alarm_uv, alarm_ot, chain_ov, chain_uv, chain_ot}
  function automatic logic [5:0] model(logic en, logic [5:0] ov, logic [5:0] uv,
                                       logic [1:0] ta, logic [1:0] sel, logic ptc,
                                       logic sep, logic [1:0] pos, logic [2:0] up);
    logic o, u, t, any;
    int   n;
    o = 0; u = 0; t = 0;
    n = 6 - int'(sel);
    for (int i = 0; i < n; i++) begin
      o = o | ov[i];
      u = u | uv[i];
    end
    for (int k = 0; k < 2; k++) t = t | (ptc ? ta[k] : ~ta[k]);
    if (pos == 2'b00 || pos == 2'b01) begin
      o = o | up[2]; u = u | up[1]; t = t | up[0];
    end
    if (!sep) begin
      any = o | u | t;
      o = any; u = any; t = any;
    end
    if (!en) begin
      o = 0; u = 0; t = 0;
    end
    return {o, u, t, o, u, t};
  endfunction

  task automatic apply(string tag, logic en, logic [5:0] ov, logic [5:0] uv,
                       logic [1:0] ta, logic [1:0] sel, logic ptc, logic sep,
                       logic [1:0] pos, logic [2:0] up);
    sb_item_t it;
    @(negedge clk);
    enable = en; cell_ov = ov; cell_uv = uv; temp_above = ta; cell_sel = sel;
    ptc_mode = ptc; separate_mode = sep; chain_pos = pos;
    {up_ov, up_uv, up_ot} = up;
    it.exp = model(en, ov, uv, ta, sel, ptc, sep, pos, up);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares one result per cycle, just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        sb_item_t it;
        logic [5:0] act;
        it  = sbq.pop_front();
        act = {alarm_ov, alarm_uv, alarm_ot, chain_ov, chain_uv, chain_ot};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: outputs actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({alarm_ov, alarm_uv, alarm_ot, chain_ov, chain_uv, chain_ot} !== 6'b0) begin
      fails++;
      $display("FAIL R8 reset: actual=%b expected=000000",
               {alarm_ov, alarm_uv, alarm_ot, chain_ov, chain_uv, chain_ot});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cell count masking
    apply("R1 six cells ov5",    1, 6'b100000, 0, 2'b11, 2'd0, 0, 1, 2'b11, 3'b000);
    apply("R1 five cells ov5",   1, 6'b100000, 0, 2'b11, 2'd1, 0, 1, 2'b11, 3'b000);
    apply("R1 five cells ov4",   1, 6'b010000, 0, 2'b11, 2'd1, 0, 1, 2'b11, 3'b000);
    apply("R1 four cells uv4",   1, 0, 6'b010000, 2'b11, 2'd2, 0, 1, 2'b11, 3'b000);
    apply("R1 three cells uv3",  1, 0, 6'b111000, 2'b11, 2'd3, 0, 1, 2'b11, 3'b000);
    apply("R1 three cells uv2",  1, 0, 6'b000100, 2'b11, 2'd3, 0, 1, 2'b11, 3'b000);
    // R2: thermistor polarity
    apply("R2 ntc warm",         1, 0, 0, 2'b11, 2'd0, 0, 1, 2'b11, 3'b000);
    apply("R2 ntc sensor0 hot",  1, 0, 0, 2'b10, 2'd0, 0, 1, 2'b11, 3'b000);
    apply("R2 ptc cool",         1, 0, 0, 2'b00, 2'd0, 1, 1, 2'b11, 3'b000);
    apply("R2 ptc sensor1 hot",  1, 0, 0, 2'b10, 2'd0, 1, 1, 2'b11, 3'b000);
    // R3: separate classes
    apply("R3 uv only",          1, 0, 6'b000001, 2'b11, 2'd0, 0, 1, 2'b11, 3'b000);
    apply("R3 ov and ot",        1, 6'b000010, 0, 2'b01, 2'd0, 0, 1, 2'b11, 3'b000);
    // R4: shared
    apply("R4 shared ov",        1, 6'b000001, 0, 2'b11, 2'd0, 0, 0, 2'b11, 3'b000);
    apply("R4 shared quiet",     1, 0, 0, 2'b11, 2'd0, 0, 0, 2'b11, 3'b000);
    apply("R4 shared upstream",  1, 0, 0, 2'b11, 2'd0, 0, 0, 2'b00, 3'b001);
    // R5: upstream accepted
    apply("R5 middle up uv",     1, 0, 0, 2'b11, 2'd0, 0, 1, 2'b00, 3'b010);
    apply("R5 bottom up ot",     1, 0, 0, 2'b11, 2'd0, 0, 1, 2'b01, 3'b001);
    // R6: upstream ignored
    apply("R6 top up all",       1, 0, 0, 2'b11, 2'd0, 0, 1, 2'b10, 3'b111);
    apply("R6 single up ov",     1, 0, 0, 2'b11, 2'd0, 0, 0, 2'b11, 3'b100);
    // R7: disabled
    apply("R7 disabled",         0, 6'h3f, 6'h3f, 2'b00, 2'd0, 0, 1, 2'b00, 3'b111);
    apply("R7 re-enabled",       1, 6'h01, 0, 2'b11, 2'd0, 0, 1, 2'b11, 3'b000);
    // R8: pseudo-random mix, chain outputs compared with local
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      r = $urandom;
      apply("R8 mixed", r[31] | r[30], r[5:0], r[11:6], r[13:12], r[15:14],
            r[16], r[17], r[19:18], r[22:20]);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule